// File: doc/BRIEF.md
# Block-Lock Status and Program Protection Unit

This unit keeps the protection state of a small serial nonvolatile memory and rules on every program request that the command decoder passes to it. It holds the program-enable latch, the two block-lock bits that lock nested upper regions of the array, and a protect-enable bit that works with an external write-protect pin (`wp_n`) to freeze the status register. A granted program request waits until the serial transfer ends properly or breaks off. A proper end starts a self-timed program cycle, and the unit counts that cycle in system clocks.

Requests arrive as one-cycle pulses with a two-bit operation code. The unit answers a status-write or array-program request with a one-cycle `grant` or `deny` pulse. A granted request then stays pending until `xfer_end` (the transfer ended at a valid point, so the cycle starts) or `xfer_abort` (the transfer ended at any other point, so nothing happens). The readable status byte is always present on `status`.

Top module: `blp_guard`

## Requirements
- R1: `status` holds bit 7 = protect enable, bits 3:2 = lock code, bit 1 = enable latch, bit 0 = busy, and bits 6:4 = 0. After power-on and reset it reads 0x00, and `busy`, `grant` and `deny` are 0.
- R2: A started program cycle keeps `busy` high for exactly CYCLES clocks. While it runs, `status` reads 0xFF.
- R3: Lock code 00 locks nothing. Code 01 locks addresses whose two top bits are 11. Code 10 locks addresses whose top bit is 1. Code 11 locks every address.
- R4: An array program request (op 3) is granted only when the enable latch is 1 and the address is unlocked. Otherwise it is denied.
- R5: Op 0 sets the enable latch and op 1 clears it. Reset clears it, and so does the end of every program cycle.
- R6: A status write (op 2) is granted only when the enable latch is 1, `wp_n` is high or protect enable is 0, and data bits 0, 1, 4, 5 and 6 are all zero. Otherwise it is denied.
- R7: If `wp_n` is low while protect enable is 1 and a granted status write is still pending, the write is dropped and `xfer_end` then starts no cycle. Once the cycle has started, `wp_n` has no effect.
- R8: A completed status write updates only protect enable and the lock code. These two fields keep their values across reset.
- R9: While a request is pending or a cycle runs, ops 0 and 1 have no effect and ops 2 and 3 are denied. `xfer_abort` drops a pending request without starting a cycle and leaves the enable latch unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high soft reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_op | input | 2 | 0 enable, 1 disable, 2 status write, 3 array program |
| req_addr | input | AW | Target array address |
| req_data | input | 8 | Status write data |
| wp_n | input | 1 | Write-protect pin level (low = protect) |
| xfer_end | input | 1 | Transfer ended at a valid point; start cycle |
| xfer_abort | input | 1 | Transfer ended early; drop pending request |
| grant | output | 1 | Request granted (pulse) |
| deny | output | 1 | Request refused (pulse) |
| busy | output | 1 | Program cycle in progress |
| status | output | 8 | Readable status byte |

## Verification
The bench builds the unit with AW = 8 and CYCLES = 6. With the narrow address, every lock region can be reached by random addresses over the two top bits. With the short cycle, the bench can count the full busy window and can drop `wp_n` in the middle of a running cycle. Directed cases cover the `wp_n` and protect-enable interplay, abort before the cycle starts, and retention across reset. Random addresses under each lock code are checked against a bench model of the lock decode.

// File: rtl/blp_pkg.sv
package blp_pkg;
  typedef enum logic [1:0] {
    OP_SET_EN = 2'd0,
    OP_CLR_EN = 2'd1,
    OP_SR_WR  = 2'd2,
    OP_PROG   = 2'd3
  } blp_op_e;

  localparam int SR_PROT_BIT = 7;
  localparam logic [7:0] SR_MUST_ZERO = 8'h73;
  localparam logic [7:0] SR_BUSY_VAL  = 8'hFF;
endpackage

// File: rtl/blp_lock_decode.sv
module blp_lock_decode #(
  parameter int AW = 13
) (
  input  logic [1:0]    lock_code,
  input  logic [AW-1:0] addr,
  output logic          locked
);
  localparam int TOP = AW - 1;

  always_comb begin
    unique case (lock_code)
      2'b00:   locked = 1'b0;
      2'b01:   locked = addr[TOP] & addr[TOP-1];
      2'b10:   locked = addr[TOP];
      default: locked = 1'b1;
    endcase
  end
endmodule

// File: rtl/blp_cycle_timer.sv
module blp_cycle_timer #(
  parameter int CYCLES = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= LOAD;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0);

  AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (cnt_q <= LOAD)); // R2
  AST_TIMER_LOAD: assert property (@(posedge clk) disable iff (rst)
    (start && !busy_q) |=> (busy_q && cnt_q == LOAD)); // R2
endmodule

// File: rtl/blp_status_bits.sv
module blp_status_bits (
  input  logic       clk,
  input  logic       rst,
  input  logic       set_en,
  input  logic       clr_en,
  input  logic       nv_wr,
  input  logic [7:0] nv_data,
  output logic       prot_en,
  output logic [1:0] lock_code,
  output logic       en_latch
);
  import blp_pkg::*;

  // Nonvolatile fields: power-on value only, untouched by soft reset.
  logic       prot_q = 1'b0;
  logic [1:0] lock_q = 2'b00;
  logic       en_q;

  always_ff @(posedge clk) begin
    if (nv_wr) begin
      prot_q <= nv_data[SR_PROT_BIT];
      lock_q <= nv_data[3:2];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         en_q <= 1'b0;
    else if (clr_en) en_q <= 1'b0;
    else if (set_en) en_q <= 1'b1;
  end

  assign prot_en   = prot_q;
  assign lock_code = lock_q;
  assign en_latch  = en_q;

  AST_NV_HOLD: assert property (@(posedge clk) disable iff (rst)
    !nv_wr |=> ($stable(prot_q) && $stable(lock_q))); // R8
  AST_EN_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr_en |=> !en_q); // R5
endmodule

// File: rtl/blp_guard.sv
module blp_guard #(
  parameter int AW     = 13,
  parameter int CYCLES = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_data,
  input  logic          wp_n,
  input  logic          xfer_end,
  input  logic          xfer_abort,
  output logic          grant,
  output logic          deny,
  output logic          busy,
  output logic [7:0]    status
);
  import blp_pkg::*;

  blp_op_e    op;
  logic       prot_en, en_latch, locked, cyc_busy, cyc_done;
  logic [1:0] lock_code;
  logic       pend_q, pend_sr_q, cyc_sr_q;
  logic [7:0] pend_data_q, cyc_data_q;
  logic       grant_q, deny_q;
  logic [7:0] status_q;
  logic       idle, accept, hw_prot, sr_bad, prog_ok, sr_ok;
  logic       pend_drop, start, is_write;

  assign op = blp_op_e'(req_op);

  blp_lock_decode #(.AW(AW)) u_lock (
    .lock_code (lock_code),
    .addr      (req_addr),
    .locked    (locked)
  );

  blp_cycle_timer #(.CYCLES(CYCLES)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .busy  (cyc_busy),
    .done  (cyc_done)
  );

  blp_status_bits u_bits (
    .clk       (clk),
    .rst       (rst),
    .set_en    (accept && op == OP_SET_EN),
    .clr_en    ((accept && op == OP_CLR_EN) || cyc_done),
    .nv_wr     (cyc_done && cyc_sr_q),
    .nv_data   (cyc_data_q),
    .prot_en   (prot_en),
    .lock_code (lock_code),
    .en_latch  (en_latch)
  );

  assign idle      = !cyc_busy && !pend_q;
  assign accept    = req_valid && idle;
  assign is_write  = (op == OP_SR_WR) || (op == OP_PROG);
  assign hw_prot   = !wp_n && prot_en;
  assign sr_bad    = |(req_data & SR_MUST_ZERO);
  assign prog_ok   = en_latch && !locked;
  assign sr_ok     = en_latch && !hw_prot && !sr_bad;
  assign pend_drop = xfer_abort || (pend_sr_q && hw_prot);
  assign start     = pend_q && xfer_end && !pend_drop;

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q     <= 1'b0;
      deny_q      <= 1'b0;
      pend_q      <= 1'b0;
      pend_sr_q   <= 1'b0;
      pend_data_q <= '0;
    end else begin
      grant_q <= 1'b0;
      deny_q  <= 1'b0;
      if (accept && op == OP_PROG) begin
        grant_q   <= prog_ok;
        deny_q    <= !prog_ok;
        pend_q    <= prog_ok;
        pend_sr_q <= 1'b0;
      end else if (accept && op == OP_SR_WR) begin
        grant_q     <= sr_ok;
        deny_q      <= !sr_ok;
        pend_q      <= sr_ok;
        pend_sr_q   <= 1'b1;
        pend_data_q <= req_data;
      end else begin
        if (req_valid && !idle && is_write) deny_q <= 1'b1;
        if (pend_q && (pend_drop || xfer_end)) pend_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_sr_q   <= 1'b0;
      cyc_data_q <= '0;
    end else if (start) begin
      cyc_sr_q   <= pend_sr_q;
      cyc_data_q <= pend_data_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= cyc_busy ? SR_BUSY_VAL
                                  : {prot_en, 3'b000, lock_code, en_latch, 1'b0};
  end

  assign grant  = grant_q;
  assign deny   = deny_q;
  assign busy   = cyc_busy;
  assign status = status_q;

  AST_BUSY_READS_FF: assert property (@(posedge clk) disable iff (rst)
    cyc_busy |=> (status_q == SR_BUSY_VAL)); // R2
  AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (rst)
    !(grant_q && deny_q)); // R4
  AST_LOCKED_REFUSED: assert property (@(posedge clk) disable iff (rst)
    (accept && op == OP_PROG && locked) |=> (deny_q && !grant_q)); // R4
  AST_GRANT_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    (accept && is_write && !en_latch) |=> !grant_q); // R6
  AST_LATCH_CLEARED_AFTER: assert property (@(posedge clk) disable iff (rst)
    $fell(cyc_busy) |-> !en_latch); // R5
  AST_HW_PROT_DROPS: assert property (@(posedge clk) disable iff (rst)
    (pend_q && pend_sr_q && hw_prot) |=> (!pend_q && !cyc_busy)); // R7
  AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !idle && is_write) |=> (deny_q && !grant_q)); // R9
endmodule

// File: tb/sim_blp_guard.sv
module sim_blp_guard;
  localparam int AW = 8;
  localparam int CYCLES = 6;
  localparam time TCLK = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0] req_data = '0;
  logic wp_n = 1'b1;
  logic xfer_end = 1'b0;
  logic xfer_abort = 1'b0;
  logic grant, deny, busy;
  logic [7:0] status;

  int checks = 0;
  int fails = 0;
  logic g_s, d_s;

  always #(TCLK/2) clk = ~clk;

  blp_guard #(.AW(AW), .CYCLES(CYCLES)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .wp_n(wp_n),
    .xfer_end(xfer_end), .xfer_abort(xfer_abort),
    .grant(grant), .deny(deny), .busy(busy), .status(status)
  );

  function automatic logic exp_locked(input logic [1:0] code, input logic [AW-1:0] a);
    case (code)
      2'b00:   return 1'b0;
      2'b01:   return a[AW-1] && a[AW-2];
      2'b10:   return a[AW-1];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] exp_status(input logic pe, input logic [1:0] lc, input logic en);
    return {pe, 3'b000, lc, en, 1'b0};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [1:0] op, input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    g_s = grant; d_s = deny;
  endtask

  task automatic pulse_end();
    @(negedge clk); xfer_end = 1'b1;
    @(negedge clk); xfer_end = 1'b0;
  endtask

  task automatic pulse_abort();
    @(negedge clk); xfer_abort = 1'b1;
    @(negedge clk); xfer_abort = 1'b0;
  endtask

  // Commit a pending request and measure the busy window.
  task automatic run_cycle(output int n, output logic [7:0] mid);
    pulse_end();
    n = 0; mid = 8'h00;
    while (busy && n < 100) begin
      n++;
      if (n == 2) mid = status;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n;
    logic [7:0] mid;
    void'($urandom(32'd1234));
    wait_n(3);
    rst = 1'b0;
    wait_n(2);
    // R1 reset state
    check("R1 reset status", status, 8'h00);
    check("R1 reset busy", busy, 0);
    check("R1 reset grant/deny", {grant, deny}, 2'b00);

    // R4 program without enable latch
    send(2'd3, 8'h00, 8'h00);
    check("R4 no latch deny", {g_s, d_s}, 2'b01);

    // R5 set then clear latch
    send(2'd0, '0, '0); wait_n(2);
    check("R5 set latch", status, exp_status(0, 2'b00, 1));
    send(2'd1, '0, '0); wait_n(2);
    check("R5 clear latch", status, exp_status(0, 2'b00, 0));

    // R6 grant status write, R2 busy window
    send(2'd0, '0, '0);
    send(2'd2, '0, 8'h8C);
    check("R6 sr write grant", {g_s, d_s}, 2'b10);
    run_cycle(n, mid);
    check("R2 busy length", n, CYCLES);
    check("R2 busy status FF", mid, 8'hFF);
    wait_n(2);
    check("R8 sr updated, R5 latch cleared", status, exp_status(1, 2'b11, 0));

    // R6 hardware protection blocks status write
    wp_n = 1'b0;
    send(2'd0, '0, '0);
    send(2'd2, '0, 8'h00);
    check("R6 hw protect deny", {g_s, d_s}, 2'b01);
    send(2'd3, 8'h05, '0);
    check("R3 code 11 locks low address", {g_s, d_s}, 2'b01);
    wait_n(2);
    check("R6 status unchanged", status, exp_status(1, 2'b11, 1));

    // R6 bad data bits
    wp_n = 1'b1;
    send(2'd2, '0, 8'h8D);
    check("R6 bad bit deny", {g_s, d_s}, 2'b01);

    // R7 wp_n drop while pending aborts
    send(2'd2, '0, 8'h84);
    check("R7 grant before abort", {g_s, d_s}, 2'b10);
    @(negedge clk); wp_n = 1'b0;
    pulse_end();
    check("R7 no cycle after drop", busy, 0);
    wait_n(2);
    check("R7 status unchanged", status, exp_status(1, 2'b11, 1));

    // R7 wp_n drop after start has no effect
    wp_n = 1'b1;
    send(2'd2, '0, 8'h84);
    pulse_end();
    wp_n = 1'b0;
    wait_n(CYCLES + 3);
    check("R7 write completes", status, exp_status(1, 2'b01, 0));
    wp_n = 1'b1;

    // R8 retention over soft reset
    @(negedge clk); rst = 1'b1;
    wait_n(2); rst = 1'b0;
    wait_n(2);
    check("R8 retained after reset", status, exp_status(1, 2'b01, 0));

    // R9 pending blocks other requests
    send(2'd0, '0, '0);
    send(2'd3, 8'h10, '0);
    check("R4 unlocked grant", {g_s, d_s}, 2'b10);
    send(2'd1, '0, '0);
    send(2'd3, 8'h10, '0);
    check("R9 pending deny", {g_s, d_s}, 2'b01);
    pulse_abort();
    check("R9 abort no cycle", busy, 0);
    wait_n(2);
    check("R9 latch kept", status, exp_status(1, 2'b01, 1));

    // R3/R4 random addresses under each lock code
    for (int c = 0; c < 4; c++) begin
      send(2'd0, '0, '0);
      send(2'd2, '0, {6'b0, 2'(c)} << 2);
      run_cycle(n, mid);
      wait_n(2);
      check("R8 code written", status, exp_status(0, 2'(c), 0));
      send(2'd0, '0, '0);
      for (int k = 0; k < 16; k++) begin
        logic [AW-1:0] a;
        logic lk;
        a = AW'($urandom);
        lk = exp_locked(2'(c), a);
        send(2'd3, a, '0);
        check("R3 lock region", {g_s, d_s}, {!lk, lk});
        if (g_s) pulse_abort();
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule